// File: doc/BRIEF.md
# E1 into C-12 Justification Mapper

This block packs one serial E1 tributary into the C-12 container carried in the four-frame super-frame of a synchronous byte bus. E1 bits arrive one at a time with a qualifying strobe in the system clock domain. They are stored in a 128-bit elastic store. Each time the bus offers a byte slot belonging to the selected VC-12, the block returns the C-12 byte for the current position in the super-frame. That byte is data, fixed stuffing, a justification control byte, or a byte holding a justification opportunity bit. The block also raises a strobe that tells the bus to replace its byte.

A super-frame spans 136 container bytes, split into four C-12s of 34 bytes each. The number of E1 bits carried per super-frame is set by the fill of the elastic store. The choice is made once, at the first byte of each super-frame. A high fill sends 1025 bits, a low fill sends 1023 bits, and otherwise 1024 bits are sent. Hysteresis around the mid fill keeps the choice from toggling. Column location, pointer bytes and path overhead bytes are handled by neighbouring logic.

Top module: `e1_c12_justify_mapper`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `add_replace` is 0 and `add_byte` is 0.
- R2: Slots offered before the first `sf_start` produce no replace strobe and consume no E1 bits. A slot offered together with `sf_start` is byte 0 of a super-frame.
- R3: An accepted slot raises `add_replace` for exactly one cycle, in the cycle after the slot, with the byte valid in that cycle. In every other cycle `add_replace` is 0 and `add_byte` is 0.
- R4: E1 bits leave in arrival order. Within a byte, the earliest bit goes to bit 7 and later bits follow downward.
- R5: In the first C-12 (byte indices 0 to 33), bytes 0 and 1 are 0 and bytes 2 to 33 are full data bytes.
- R6: The second and third C-12s start at indices 34 and 68. Each starts with a control byte with C1 in bit 7, C2 in bit 6 and 0 in bits 5 to 0. A zero stuffing byte follows, then 32 data bytes.
- R7: The fourth C-12 starts at index 102. Its control byte carries C1 in bit 7, C2 in bit 6 and opportunity S1 in bit 0, with bits 5 to 1 set to 0. Index 103 carries 7 data bits in bits 7 to 1 and opportunity S2 in bit 0. Index 104 is 0, and indices 105 to 135 are data. An opportunity that is not used for data is sent as 0.
- R8: If the store fill at byte 0 is at least 96, the super-frame uses the "more" mode. C1 and C2 are both 1, and both S1 and S2 carry data (1025 bits).
- R9: If the store fill at byte 0 is at most 32, the super-frame uses the "less" mode. C1 and C2 are both 0, and neither S1 nor S2 carries data (1023 bits).
- R10: Otherwise the super-frame uses the nominal mode: C1 is 0, C2 is 1, only S2 carries data (1024 bits). The exception is hysteresis: a "more" mode is kept while the fill is above 64, and a "less" mode is kept while the fill is below 64.
- R11: The mode chosen at byte 0 holds for all 136 bytes of that super-frame.
- R12: After index 135 the index wraps to 0 on its own, and a new decision is made there. An `sf_start` on any accepted slot restarts the index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e1_bit | input | 1 | Serial E1 data bit |
| e1_valid | input | 1 | Qualifies `e1_bit` for one cycle |
| slot_req | input | 1 | Bus offers a byte slot of the selected VC-12 container |
| sf_start | input | 1 | With `slot_req`, marks byte 0 of the super-frame |
| add_byte | output | 8 | Container byte for the offered slot |
| add_replace | output | 1 | Bus must substitute `add_byte` in this cycle |

## Verification
The assertions assume that the E1 input and the slot rate together never let the store run dry: a slot is never given more data bits than the store holds. They also assume the fill never reaches 128 bits. The stimulus respects both by spacing slots eight cycles apart and fixing the exact number of E1 bits per super-frame. It then steers that number from the modelled fill, so the fill climbs through 96, falls back through 64, sinks to 32 and recovers. The swing stays tens of bits away from empty or full.

// File: rtl/e1map_pkg.sv
package e1map_pkg;
    typedef enum logic [1:0] {
        JUST_NOM  = 2'd0,
        JUST_MORE = 2'd1,
        JUST_LESS = 2'd2
    } just_mode_e;
endpackage

// File: rtl/e1_bit_store.sv
// Circular bit store: one write per cycle, up to RDW bits read per cycle.
module e1_bit_store #(
    parameter int DEPTH = 128,
    parameter int RDW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1),
    localparam int CW   = $clog2(RDW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic [CW-1:0] rd_cnt,
    output logic [RDW-1:0] head,
    output logic [FW-1:0] fill
);
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [FW-1:0]    fill;
    } st_t;

    st_t q, d;
    logic [FW-1:0] after_rd;

    always_comb begin
        d        = q;
        after_rd = q.fill - FW'(rd_cnt);
        d.rp     = q.rp + AW'(rd_cnt);
        if (wr_en && (after_rd < FULL)) begin
            d.mem[q.wp] = wr_bit;
            d.wp        = q.wp + 1'b1;
            after_rd    = after_rd + 1'b1;
        end
        d.fill = after_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    generate
        for (genvar i = 0; i < RDW; i++) begin : g_head
            assign head[RDW-1-i] = q.mem[q.rp + AW'(i)];
        end
    endgenerate

    assign fill = q.fill;
endmodule

// File: rtl/c12_slot_map.sv
// Byte shape for a super-frame index: which bits are data, fixed values.
module c12_slot_map
    import e1map_pkg::*;
#(
    parameter int C12_BYTES = 34,
    localparam int IW       = $clog2(4 * C12_BYTES)
) (
    input  logic [IW-1:0] idx,
    input  just_mode_e    mode,
    output logic [7:0]    mask,
    output logic [7:0]    fixed,
    output logic [3:0]    n_data
);
    localparam logic [IW-1:0] B1 = IW'(C12_BYTES);
    localparam logic [IW-1:0] B2 = IW'(2 * C12_BYTES);
    localparam logic [IW-1:0] B3 = IW'(3 * C12_BYTES);

    logic c1, c2;
    logic [IW-1:0] rel;

    assign c1 = (mode == JUST_MORE);
    assign c2 = (mode != JUST_LESS);

    always_comb begin
        mask  = 8'h00;
        fixed = 8'h00;
        rel   = '0;
        if (idx < B1) begin
            rel = idx;
            if (rel >= IW'(2)) mask = 8'hFF;
        end else if (idx < B3) begin
            rel = (idx < B2) ? idx - B1 : idx - B2;
            if (rel == '0)         fixed = {c1, c2, 6'b0};
            else if (rel >= IW'(2)) mask = 8'hFF;
        end else begin
            rel = idx - B3;
            if (rel == '0) begin
                fixed = {c1, c2, 6'b0};
                mask  = c1 ? 8'h01 : 8'h00;
            end else if (rel == IW'(1)) begin
                mask  = c2 ? 8'hFF : 8'hFE;
            end else if (rel >= IW'(3)) begin
                mask  = 8'hFF;
            end
        end
    end

    always_comb begin
        n_data = 4'd0;
        for (int b = 0; b < 8; b++) n_data = n_data + {3'b0, mask[b]};
    end
endmodule

// File: rtl/e1_c12_justify_mapper.sv
module e1_c12_justify_mapper
    import e1map_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int LO_MARK    = 32,
    parameter int HI_MARK    = 96,
    parameter int C12_BYTES  = 34
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e1_bit,
    input  logic       e1_valid,
    input  logic       slot_req,
    input  logic       sf_start,
    output logic [7:0] add_byte,
    output logic       add_replace
);
    localparam int SF_BYTES = 4 * C12_BYTES;
    localparam int IW       = $clog2(SF_BYTES);
    localparam int FW       = $clog2(FIFO_DEPTH + 1);
    localparam int CW       = $clog2(9);
    localparam logic [IW-1:0] LAST = IW'(SF_BYTES - 1);
    localparam logic [FW-1:0] LO   = FW'(LO_MARK);
    localparam logic [FW-1:0] HI   = FW'(HI_MARK);
    localparam logic [FW-1:0] MID  = FW'((LO_MARK + HI_MARK) / 2);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          synced;
        just_mode_e    mode;
        logic [7:0]    obyte;
        logic          orep;
    } st_t;

    st_t q, d;

    logic          take;
    logic [IW-1:0] cur_idx;
    logic [7:0]    map_mask, map_fixed, head;
    logic [3:0]    map_n;
    logic [CW-1:0] rd_cnt;
    logic [FW-1:0] fill;
    logic [2:0]    ptr;

    assign take    = slot_req && (sf_start || q.synced);
    assign cur_idx = sf_start ? '0 : q.idx;
    assign rd_cnt  = take ? CW'(map_n) : '0;

    e1_bit_store #(.DEPTH(FIFO_DEPTH), .RDW(8)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (e1_valid),
        .wr_bit (e1_bit),
        .rd_cnt (rd_cnt),
        .head   (head),
        .fill   (fill)
    );

    c12_slot_map #(.C12_BYTES(C12_BYTES)) u_map (
        .idx    (cur_idx),
        .mode   (q.mode),
        .mask   (map_mask),
        .fixed  (map_fixed),
        .n_data (map_n)
    );

    function automatic just_mode_e pick_mode(logic [FW-1:0] f, just_mode_e cur);
        if (f >= HI)                            return JUST_MORE;
        else if (f <= LO)                       return JUST_LESS;
        else if (cur == JUST_MORE && f > MID)   return JUST_MORE;
        else if (cur == JUST_LESS && f < MID)   return JUST_LESS;
        else                                    return JUST_NOM;
    endfunction

    always_comb begin
        d       = q;
        d.orep  = 1'b0;
        d.obyte = 8'h00;
        ptr     = 3'd7;
        if (take) begin
            d.synced = 1'b1;
            d.orep   = 1'b1;
            if (cur_idx == '0) d.mode = pick_mode(fill, q.mode);
            for (int b = 7; b >= 0; b--) begin
                if (map_mask[3'(b)]) begin
                    d.obyte[3'(b)] = head[ptr];
                    ptr            = ptr - 3'd1;
                end else begin
                    d.obyte[3'(b)] = map_fixed[3'(b)];
                end
            end
            d.idx = (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign add_byte    = q.obyte;
    assign add_replace = q.orep;

    logic [IW-1:0] idx_q;
    logic [1:0]    mode_q;
    logic          synced_q;
    assign idx_q    = q.idx;
    assign mode_q   = q.mode;
    assign synced_q = q.synced;
endmodule

// File: rtl/e1_c12_justify_mapper_chk.sv
module e1_c12_justify_mapper_chk #(
    parameter int DEPTH = 128,
    parameter int IW    = 8,
    parameter int FW    = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_req,
    input logic          sf_start,
    input logic          add_replace,
    input logic [7:0]    add_byte,
    input logic [IW-1:0] idx_q,
    input logic [1:0]    mode_q,
    input logic          synced_q,
    input logic [FW-1:0] fill,
    input logic [CW-1:0] rd_cnt
);
    // R3
    replace_has_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_replace |-> $past(slot_req));

    // R3
    accepted_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slot_req && (sf_start || synced_q)) |-> add_replace);

    // R5
    first_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_replace && $past(sf_start)) |-> (add_byte == 8'h00));

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |->
            $past(slot_req && (sf_start || (synced_q && idx_q == '0))));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        FW'(rd_cnt) <= fill);

    // R4
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));
endmodule

bind e1_c12_justify_mapper e1_c12_justify_mapper_chk #(
    .DEPTH(FIFO_DEPTH), .IW(IW), .FW(FW), .CW(CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_req    (slot_req),
    .sf_start    (sf_start),
    .add_replace (add_replace),
    .add_byte    (add_byte),
    .idx_q       (idx_q),
    .mode_q      (mode_q),
    .synced_q    (synced_q),
    .fill        (fill),
    .rd_cnt      (rd_cnt)
);

// File: tb/test_e1_c12_justify_mapper.sv
`timescale 1ns/1ps
module test_e1_c12_justify_mapper;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, e1_bit, e1_valid, slot_req, sf_start;
    logic [7:0] add_byte;
    logic add_replace;

    e1_c12_justify_mapper i_e1_c12_justify_mapper (
        .clk(clk), .rst_n(rst_n), .e1_bit(e1_bit), .e1_valid(e1_valid),
        .slot_req(slot_req), .sf_start(sf_start),
        .add_byte(add_byte), .add_replace(add_replace)
    );

    int total = 0, bad = 0;
    bit qb [0:262143];
    int qh = 0, qt = 0;
    int m_idx = 0;
    bit m_sync = 0;
    int m_mode = 0; // 0 nominal, 1 more, 2 less
    int n_nom = 0, n_more = 0, n_less = 0;
    bit done = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int decide(int f, int cur);
        if (f >= 96) return 1;
        if (f <= 32) return 2;
        if (cur == 1 && f > 64) return 1;
        if (cur == 2 && f < 64) return 2;
        return 0;
    endfunction

    // Byte shape from the layout requirements R5..R10
    task automatic shape(int idx, int mode, output logic [7:0] mask, output logic [7:0] fixed);
        int c = idx / 34, r = idx % 34;
        bit cc1 = (mode == 1), cc2 = (mode != 2);
        mask = 8'h00; fixed = 8'h00;
        if (c == 0) begin
            if (r >= 2) mask = 8'hFF;
        end else if (c < 3) begin
            if (r == 0) fixed = {cc1, cc2, 6'b0};
            else if (r >= 2) mask = 8'hFF;
        end else begin
            if (r == 0) begin fixed = {cc1, cc2, 6'b0}; mask = cc1 ? 8'h01 : 8'h00; end
            else if (r == 1) mask = cc2 ? 8'hFF : 8'hFE;
            else if (r >= 3) mask = 8'hFF;
        end
    endtask

    function automatic string tag_of(int idx);
        if (idx == 0 || idx == 1) return "R5/R12";
        if (idx == 34 || idx == 68) return "R6/R11";
        if (idx == 35 || idx == 69) return "R6";
        if (idx >= 102 && idx <= 104) return "R7/R11";
        return "R4";
    endfunction

    task automatic step(bit sl, bit sf, bit ev, bit eb);
        logic exp_rep;
        logic [7:0] exp_byte, mask, fixed;
        string tag;
        slot_req = sl; sf_start = sf; e1_valid = ev; e1_bit = eb;
        exp_rep = 0; exp_byte = 8'h00;
        tag = sl ? "R2" : "R3";
        if (sl && (sf || m_sync)) begin
            if (sf) m_idx = 0;
            m_sync = 1;
            if (m_idx == 0) begin
                m_mode = decide(qt - qh, m_mode);
                if (m_mode == 1) n_more++; else if (m_mode == 2) n_less++; else n_nom++;
            end
            shape(m_idx, m_mode, mask, fixed);
            for (int b = 7; b >= 0; b--) begin
                if (mask[b]) begin exp_byte[b] = qb[qh]; qh++; end
                else exp_byte[b] = fixed[b];
            end
            exp_rep = 1;
            tag = tag_of(m_idx);
            m_idx = (m_idx == 135) ? 0 : m_idx + 1;
        end
        if (ev) begin qb[qt] = eb; qt++; end
        @(posedge clk);
        @(negedge clk);
        check(add_replace == exp_rep, exp_rep ? "R3" : tag, int'(add_replace), int'(exp_rep));
        check(add_byte == exp_byte, tag, int'(add_byte), int'(exp_byte));
    endtask

    task automatic run_frame(int nslots, int kbits, bit give_sf);
        int cycles = nslots * 8;
        int r = kbits;
        for (int c = 0; c < cycles; c++) begin
            bit ev = ($urandom_range(cycles - c - 1, 0) < r);
            if (ev) r--;
            step(c % 8 == 0, give_sf && c == 0, ev, 1'($urandom_range(1, 0)));
        end
    endtask

    initial begin
        int phase = 0, tail = 0, k;
        void'($urandom(32'd4242));
        rst_n = 0; slot_req = 0; sf_start = 0; e1_valid = 0; e1_bit = 0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(add_replace == 1'b0, "R1", int'(add_replace), 0);
        check(add_byte == 8'h00, "R1", int'(add_byte), 0);
        rst_n = 1;
        // R2: preload 64 bits while slots arrive without any frame start
        for (int c = 0; c < 64; c++) step(c % 8 == 0, 0, 1, 1'($urandom_range(1, 0)));
        // Adaptive frames drive the fill through both marks (R8, R9, R10);
        // every third frame runs without sf_start to exercise the wrap (R12)
        for (int f = 0; f < 40 && phase < 5; f++) begin
            case (phase)
                0: k = 1032;
                1: k = 1018;
                2: k = 1014;
                3: k = 1030;
                default: k = 1024;
            endcase
            run_frame(136, k, (f % 3) != 2);
            if (phase == 0 && m_mode == 1) phase = 1;
            else if (phase == 1 && m_mode == 0) phase = 2;
            else if (phase == 2 && m_mode == 2) phase = 3;
            else if (phase == 3 && m_mode == 0) phase = 4;
            else if (phase == 4) begin tail++; if (tail == 2) phase = 5; end
        end
        // R12: restart in the middle of a super-frame
        run_frame(50, 376, 1);
        run_frame(136, 1024, 1);
        run_frame(136, 1024, 1);
        check(n_more > 0, "R8", n_more, 1);
        check(n_less > 0, "R9", n_less, 1);
        check(n_nom > 0, "R10", n_nom, 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule